// File: doc/BRIEF.md
# Capability Metadata Cache

This block keeps recently used namespace metadata records close to the memory management logic. A request carries a 64-bit namespace identifier. The cache looks that identifier up in the same cycle the translation buffer is searched. On a hit, it hands the full record to the downstream permission checker combinationally. The record holds the lower and upper byte bounds, the read/write/execute/valid permission bits, the page-table physical page number, the root and parent identifiers, and a pointer to the child list.

When the identifier is not resident, a mode input selects what happens. In fault mode, the miss is reported at once as a fault. In walk mode, the cache stalls the requester, fetches the record from the metadata directory over a simple read interface and installs it. The requester then repeats the lookup and hits. A revoke port removes a namespace from the cache, so a stale copy can never keep granting access after revocation. Free-running hit and miss counters support performance monitoring.

The cache is set-associative. The set index is the low `log2(SETS)` bits of the identifier, and the tag is the remaining upper bits. The default size is 16 sets of 8 ways (128 records).

Top module: `nsmeta_cache`

## Requirements
- R1: When `lk_valid` and `lk_ready` are high and the identifier is resident, `lk_hit` is high in the same cycle and `lk_rec` equals the record installed for that identifier. The record is packed, from the most significant bit down, as: lower bound, upper bound, permissions {read, write, execute, valid}, page-table PPN, root ID, parent ID, child-list pointer.
- R2: A non-resident lookup with `walk_en` low raises `lk_fault` in the same cycle. It issues no fill request, and `lk_ready` stays high.
- R3: A non-resident lookup with `walk_en` high raises `fill_req_valid` for exactly one cycle, on the cycle after the lookup, with `fill_req_id` equal to the looked-up identifier. `lk_ready` is low from that cycle until the cycle after `fill_rsp_valid`. While `lk_ready` is low, neither `lk_hit` nor `lk_fault` is raised.
- R4: A record returned on `fill_rsp_rec` is installed in the set given by the low identifier bits. A later lookup of the same identifier hits and returns it.
- R5: On a fill, the victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the set's round-robin pointer. After each install, the pointer moves to the way after the victim, wrapping at the last way.
- R6: A revoke of a resident identifier invalidates its entry at the next clock edge, so later lookups of it miss. Other resident entries remain hits.
- R7: A lookup presented in the same cycle as a revoke of the same identifier does not hit.
- R8: If the identifier being fetched is revoked while the fill is outstanding (including in the lookup cycle itself), the returned record is discarded and not installed.
- R9: `hit_cnt` increments by one for each accepted lookup that hits. `miss_cnt` increments by one for each accepted lookup that misses, in either mode. A lookup is accepted when `lk_valid` and `lk_ready` are both high.
- R10: After reset, every entry is invalid, `lk_ready` is high, `fill_req_valid` is low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_en | input | 1 | Miss handling: 1 = fetch from directory, 0 = fault |
| lk_valid | input | 1 | Lookup request valid |
| lk_id | input | 64 | Namespace identifier to look up |
| lk_ready | output | 1 | High when a lookup can be accepted |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| lk_fault | output | 1 | Lookup missed in fault mode (same cycle) |
| lk_rec | output | REC_W | Metadata record of the hitting entry |
| rvk_valid | input | 1 | Revoke request valid |
| rvk_id | input | 64 | Namespace identifier to revoke |
| fill_req_valid | output | 1 | One-cycle directory read request |
| fill_req_id | output | 64 | Identifier to fetch |
| fill_rsp_valid | input | 1 | Directory read data valid |
| fill_rsp_rec | input | REC_W | Record returned by the directory |
| hit_cnt | output | CNT_W | Accepted-hit counter |
| miss_cnt | output | CNT_W | Accepted-miss counter |

## Verification
The bench uses a small configuration of 4 sets by 2 ways, so that three identifiers sharing a set force an eviction. It then confirms which identifier survived. A design that picks the wrong victim would let the wrong one fault.

Three revocation corner cases are covered:
- A revoke of a resident entry. A design that ignores it would keep returning the stale record.
- A revoke in the same cycle as a lookup of that identifier. A design that reads the array before applying the revoke would hit there.
- A revoke while a fill for that identifier is outstanding. A design that installs the returned record anyway would later hit instead of fault.

The counters are compared against totals the bench keeps itself. This catches double counting during the walk stall, or a miss left uncounted in fault mode.

// File: rtl/nsmc_pkg.sv
package nsmc_pkg;

    parameter int unsigned NS_ID_W = 64;
    parameter int unsigned BND_W   = 64;
    parameter int unsigned PPN_W   = 44;
    parameter int unsigned PTR_W   = 64;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic ok;
    } perm_t;

    typedef struct packed {
        logic [BND_W-1:0]   lo_bnd;
        logic [BND_W-1:0]   hi_bnd;
        perm_t              perm;
        logic [PPN_W-1:0]   pt_ppn;
        logic [NS_ID_W-1:0] root_id;
        logic [NS_ID_W-1:0] parent_id;
        logic [PTR_W-1:0]   kids_ptr;
    } ns_rec_t;

    localparam int unsigned REC_W = $bits(ns_rec_t);

endpackage

// File: rtl/nsmc_way_match.sv
module nsmc_way_match #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned TAG_W = 60,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            vld,
    input  logic [TAG_W-1:0]           key,
    output logic                       any,
    output logic [WAY_W-1:0]           way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
    end

    assign any = |match;

endmodule

// File: rtl/nsmc_victim.sv
module nsmc_victim #(
    parameter int unsigned WAYS = 8,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAY_W-1:0] rr,
    output logic [WAY_W-1:0] way
);
    logic             has_free;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        way = has_free ? free_way : rr;
    end

endmodule

// File: rtl/nsmeta_cache.sv
module nsmeta_cache
    import nsmc_pkg::*;
#(
    parameter int unsigned SETS  = 16,
    parameter int unsigned WAYS  = 8,
    parameter int unsigned CNT_W = 32,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = NS_ID_W - IDX_W,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               walk_en,
    input  logic               lk_valid,
    input  logic [NS_ID_W-1:0] lk_id,
    output logic               lk_ready,
    output logic               lk_hit,
    output logic               lk_fault,
    output logic [REC_W-1:0]   lk_rec,
    input  logic               rvk_valid,
    input  logic [NS_ID_W-1:0] rvk_id,
    output logic               fill_req_valid,
    output logic [NS_ID_W-1:0] fill_req_id,
    input  logic               fill_rsp_valid,
    input  logic [REC_W-1:0]   fill_rsp_rec,
    output logic [CNT_W-1:0]   hit_cnt,
    output logic [CNT_W-1:0]   miss_cnt
);

    typedef enum logic {ST_IDLE, ST_WAIT} fsm_t;

    typedef struct {
        fsm_t               fsm;
        logic [NS_ID_W-1:0] pend_id;
        logic               drop;
        logic               req;
        logic [TAG_W-1:0]   tag [SETS][WAYS];
        ns_rec_t            dat [SETS][WAYS];
        logic [WAYS-1:0]    vld [SETS];
        logic [WAY_W-1:0]   rr  [SETS];
        logic [CNT_W-1:0]   hits;
        logic [CNT_W-1:0]   misses;
    } state_t;

    state_t st_d, st_q;

    // Address split for lookup, revoke and pending fill
    logic [IDX_W-1:0] lk_set, rv_set, pd_set;
    logic [TAG_W-1:0] lk_tag, rv_tag, pd_tag;

    assign lk_set = lk_id[IDX_W-1:0];
    assign lk_tag = lk_id[NS_ID_W-1:IDX_W];
    assign rv_set = rvk_id[IDX_W-1:0];
    assign rv_tag = rvk_id[NS_ID_W-1:IDX_W];
    assign pd_set = st_q.pend_id[IDX_W-1:0];
    assign pd_tag = st_q.pend_id[NS_ID_W-1:IDX_W];

    logic [WAYS-1:0][TAG_W-1:0] lk_tags, rv_tags;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_tags[w] = st_q.tag[lk_set][w];
            rv_tags[w] = st_q.tag[rv_set][w];
        end
    end

    logic             lk_any, rv_any;
    logic [WAY_W-1:0] lk_way, rv_way, vic_way;

    nsmc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .tags (lk_tags),
        .vld  (st_q.vld[lk_set]),
        .key  (lk_tag),
        .any  (lk_any),
        .way  (lk_way)
    );

    nsmc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rv_match (
        .tags (rv_tags),
        .vld  (st_q.vld[rv_set]),
        .key  (rv_tag),
        .any  (rv_any),
        .way  (rv_way)
    );

    nsmc_victim #(.WAYS(WAYS)) u_victim (
        .vld (st_q.vld[pd_set]),
        .rr  (st_q.rr[pd_set]),
        .way (vic_way)
    );

    logic idle, kill_same, take, hit_now, miss_now, rv_pend;

    assign idle      = (st_q.fsm == ST_IDLE);
    assign kill_same = rvk_valid && (rvk_id == lk_id);
    assign take      = lk_valid && idle;
    assign hit_now   = take && lk_any && !kill_same;
    assign miss_now  = take && !(lk_any && !kill_same);
    assign rv_pend   = rvk_valid && (rvk_id == st_q.pend_id);

    assign lk_ready       = idle;
    assign lk_hit         = hit_now;
    assign lk_fault       = miss_now && !walk_en;
    assign lk_rec         = st_q.dat[lk_set][lk_way];
    assign fill_req_valid = st_q.req;
    assign fill_req_id    = st_q.pend_id;
    assign hit_cnt        = st_q.hits;
    assign miss_cnt       = st_q.misses;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;

        if (hit_now)  st_d.hits   = st_q.hits + CNT_W'(1);
        if (miss_now) st_d.misses = st_q.misses + CNT_W'(1);

        // Revoke first, so a same-cycle install is not undone
        if (rvk_valid && rv_any) st_d.vld[rv_set][rv_way] = 1'b0;

        if (st_q.fsm == ST_WAIT) begin
            if (rv_pend) st_d.drop = 1'b1;
            if (fill_rsp_valid) begin
                st_d.fsm  = ST_IDLE;
                st_d.drop = 1'b0;
                if (!st_q.drop && !rv_pend) begin
                    st_d.tag[pd_set][vic_way] = pd_tag;
                    st_d.dat[pd_set][vic_way] = ns_rec_t'(fill_rsp_rec);
                    st_d.vld[pd_set][vic_way] = 1'b1;
                    st_d.rr[pd_set] = (vic_way == WAY_W'(WAYS - 1)) ?
                                      '0 : vic_way + WAY_W'(1);
                end
            end
        end else if (miss_now && walk_en) begin
            st_d.fsm     = ST_WAIT;
            st_d.pend_id = lk_id;
            st_d.drop    = kill_same;
            st_d.req     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fsm     <= ST_IDLE;
            st_q.pend_id <= '0;
            st_q.drop    <= 1'b0;
            st_q.req     <= 1'b0;
            st_q.hits    <= '0;
            st_q.misses  <= '0;
            for (int s = 0; s < SETS; s++) begin
                st_q.vld[s] <= '0;
                st_q.rr[s]  <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    st_q.tag[s][w] <= '0;
                    st_q.dat[s][w] <= '0;
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    AST_FAULT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (!walk_en && lk_ready && !lk_hit)); // R2

    AST_FILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> $past(lk_valid && lk_ready && !lk_hit && walk_en)); // R3

    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |=> !fill_req_valid); // R3

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |-> (!lk_hit && !lk_fault)); // R3

    AST_NO_REVOKED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rvk_valid && lk_valid && rvk_id == lk_id) |-> !lk_hit); // R7

    AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> (hit_cnt == $past(hit_cnt) + CNT_W'(1))); // R9

    AST_MISS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && !lk_hit) |=> (miss_cnt == $past(miss_cnt) + CNT_W'(1))); // R9

endmodule

// File: tb/nsmeta_cache_tb_top.sv
module nsmeta_cache_tb_top;
    import nsmc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               walk_en = 1'b0;
    logic               lk_valid = 1'b0;
    logic [NS_ID_W-1:0] lk_id = '0;
    logic               lk_ready, lk_hit, lk_fault;
    logic [REC_W-1:0]   lk_rec;
    logic               rvk_valid = 1'b0;
    logic [NS_ID_W-1:0] rvk_id = '0;
    logic               fill_req_valid;
    logic [NS_ID_W-1:0] fill_req_id;
    logic               fill_rsp_valid;
    logic [REC_W-1:0]   fill_rsp_rec;
    logic [CNT_W-1:0]   hit_cnt, miss_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nsmeta_cache #(.SETS(4), .WAYS(2), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .walk_en(walk_en),
        .lk_valid(lk_valid), .lk_id(lk_id), .lk_ready(lk_ready),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_rec(lk_rec),
        .rvk_valid(rvk_valid), .rvk_id(rvk_id),
        .fill_req_valid(fill_req_valid), .fill_req_id(fill_req_id),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_rec(fill_rsp_rec),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    function automatic logic [REC_W-1:0] rec_of(input logic [NS_ID_W-1:0] id);
        ns_rec_t r;
        r.lo_bnd    = id << 8;
        r.hi_bnd    = (id << 8) | 64'hFF;
        r.perm      = perm_t'(id[3:0] ^ 4'h9);
        r.pt_ppn    = id[PPN_W-1:0] ^ 44'h5A5;
        r.root_id   = ~id;
        r.parent_id = id + 64'd1;
        r.kids_ptr  = {id[31:0], id[63:32]};
        return REC_W'(r);
    endfunction

    // Directory model: answers each one-cycle request a few cycles later
    logic [2:0]         mem_cnt;
    logic [NS_ID_W-1:0] mem_id;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cnt        <= '0;
            mem_id         <= '0;
            fill_rsp_valid <= 1'b0;
            fill_rsp_rec   <= '0;
        end else begin
            fill_rsp_valid <= 1'b0;
            if (fill_req_valid) begin
                mem_cnt <= 3'd3;
                mem_id  <= fill_req_id;
            end else if (mem_cnt != 0) begin
                mem_cnt <= mem_cnt - 3'd1;
                if (mem_cnt == 3'd1) begin
                    fill_rsp_valid <= 1'b1;
                    fill_rsp_rec   <= rec_of(mem_id);
                end
            end
        end
    end

    int n_run = 0, n_fail = 0, exp_hits = 0, exp_miss = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 50 && !lk_ready; k++) @(negedge clk);
        chk("R3 ready returns", REC_W'(lk_ready), REC_W'(1));
    endtask

    // Present a lookup, check same-cycle result, complete any walk
    task automatic do_lookup(input logic [NS_ID_W-1:0] id, input logic walk,
                             input logic e_hit, input logic e_fault);
        @(negedge clk);
        lk_valid = 1'b1; lk_id = id; walk_en = walk;
        #1;
        chk("R1 hit flag", REC_W'(lk_hit), REC_W'(e_hit));
        chk("R2 fault flag", REC_W'(lk_fault), REC_W'(e_fault));
        if (e_hit) begin
            chk("R1 record", lk_rec, rec_of(id));
            exp_hits++;
        end else begin
            exp_miss++;
        end
        @(negedge clk);
        if (!e_hit && walk) begin
            chk("R3 fill request", REC_W'(fill_req_valid), REC_W'(1));
            chk("R3 fill id", REC_W'(fill_req_id), REC_W'(id));
            chk("R3 stall", REC_W'(lk_ready), REC_W'(0));
            wait_ready();
            #1;
            chk("R4 refill hit", REC_W'(lk_hit), REC_W'(1));
            chk("R4 refill record", lk_rec, rec_of(id));
            exp_hits++;
            @(negedge clk);
        end else if (!e_hit) begin
            chk("R2 no fill", REC_W'(fill_req_valid), REC_W'(0));
        end
        lk_valid = 1'b0;
    endtask

    localparam logic [NS_ID_W-1:0] ID_A = 64'h10, ID_B = 64'h20, ID_C = 64'h30,
                                   ID_D = 64'h11, ID_E = 64'h12;

    // {id, walk, expected hit, expected fault}; 4 sets x 2 ways, A/B/C share set 0
    localparam int NV = 11;
    localparam logic [NS_ID_W+2:0] VEC [NV] = '{
        {ID_A, 1'b0, 1'b0, 1'b1},  // R2 cold miss faults
        {ID_A, 1'b1, 1'b0, 1'b0},  // R3 walk, A to way 0
        {ID_A, 1'b0, 1'b1, 1'b0},  // R4 resident
        {ID_B, 1'b1, 1'b0, 1'b0},  // R5 B to free way 1
        {ID_C, 1'b1, 1'b0, 1'b0},  // R5 set full, pointer 0 evicts A
        {ID_B, 1'b0, 1'b1, 1'b0},  // R5 B survives
        {ID_A, 1'b0, 1'b0, 1'b1},  // R5 A was evicted
        {ID_A, 1'b1, 1'b0, 1'b0},  // R5 pointer 1 evicts B
        {ID_B, 1'b0, 1'b0, 1'b1},  // R5 B evicted
        {ID_C, 1'b0, 1'b1, 1'b0},  // R5 C survives
        {ID_D, 1'b0, 1'b0, 1'b1}   // R2 other set empty
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready", REC_W'(lk_ready), REC_W'(1));
        chk("R10 no fill", REC_W'(fill_req_valid), REC_W'(0));
        chk("R10 hit count", REC_W'(hit_cnt), REC_W'(0));
        chk("R10 miss count", REC_W'(miss_cnt), REC_W'(0));

        for (int i = 0; i < NV; i++) begin
            do_lookup(VEC[i][NS_ID_W+2:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R6: revoke resident C, A untouched
        @(negedge clk); rvk_valid = 1'b1; rvk_id = ID_C;
        @(negedge clk); rvk_valid = 1'b0;
        do_lookup(ID_C, 1'b0, 1'b0, 1'b1);  // R6 revoked entry misses
        do_lookup(ID_A, 1'b0, 1'b1, 1'b0);  // R6 neighbour still hits

        // R7: lookup and revoke of A in the same cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_id = ID_A; walk_en = 1'b0;
        rvk_valid = 1'b1; rvk_id = ID_A;
        #1;
        chk("R7 no hit on revoke", REC_W'(lk_hit), REC_W'(0));
        chk("R7 fault", REC_W'(lk_fault), REC_W'(1));
        exp_miss++;
        @(negedge clk); lk_valid = 1'b0; rvk_valid = 1'b0;
        do_lookup(ID_A, 1'b0, 1'b0, 1'b1);  // R7 entry gone

        // R8: revoke while the fill of E is outstanding
        @(negedge clk);
        lk_valid = 1'b1; lk_id = ID_E; walk_en = 1'b1;
        exp_miss++;
        @(negedge clk);
        lk_valid = 1'b0;
        rvk_valid = 1'b1; rvk_id = ID_E;
        @(negedge clk); rvk_valid = 1'b0;
        wait_ready();
        do_lookup(ID_E, 1'b0, 1'b0, 1'b1);  // R8 discarded fill

        // R9 counters
        @(negedge clk);
        chk("R9 hit count", REC_W'(hit_cnt), REC_W'(exp_hits));
        chk("R9 miss count", REC_W'(miss_cnt), REC_W'(exp_miss));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule